// File: doc/BRIEF.md
# Flash Region Decoder with Boot-Time Vector Remap

This block sits between a processor's flash request path and the flash controller. For each request it works out which of four areas the address falls in: the main application area, the data area carved from the top of the application space, the 4 KB loader area, or the three configuration words. It returns that area together with the offset inside it. It also reports an error for addresses that match no area, and a permission bit that governs changes to the configuration words.

Boot settings are captured while reset is held. These are the boot source, the data-area enable (active low) and the data-area base. Once reset is released they stay frozen, so later edits to the configuration words only matter after the next reset.

The boot source decides where the 512-byte vector window at address zero points: the application area or the start of the loader area. One boot setting also allows firmware to move that window at run time. The result of each request is registered and appears one cycle after the request.

Top module: `flash_region_map`

## Requirements
- R1: While reset is held, and after it, the outputs are zero until a request is made: out_valid=0, out_err=0, out_perm=0, out_region=0. Region codes are: 0 none, 1 application, 2 data, 3 loader, 4 configuration.
- R2: Addresses 0x0010_0000 to 0x0010_0FFF decode to region 3, with offset equal to the address minus 0x0010_0000. Address 0x0010_1000 is unmapped.
- R3: Addresses 0x0030_0000 to 0x0030_000B decode to region 4, with offset equal to the address minus 0x0030_0000. Address 0x0030_000C is unmapped.
- R4: With cfg_data_off=1, addresses 0x0000_0000 to 0x0007_FFFF decode to region 1 with offset equal to the address. Address 0x0008_0000 is unmapped.
- R5: With cfg_data_off=0, the base is cfg_data_base with its low 12 bits cleared. Addresses below the base are region 1. Addresses from the base to 0x0007_FFFF are region 2, with offset equal to the address minus the base.
- R6: With boot field 00, addresses 0x0000_0000 to 0x0000_01FF decode to region 3 with offset equal to the address. Address 0x0000_0200 follows the normal application/data decode.
- R7: With boot field 01, the vector window decodes as application space, and remap_req has no effect.
- R8: With boot field 1x, the window starts at application space. A remap_req sets the window's target from remap_to_ldr (1 = loader, 0 = application). The change applies to requests issued in the cycle after remap_req and later, and it alters nothing outside the window.
- R9: cfg_boot_sel, cfg_data_off and cfg_data_base are sampled only while rst_n is low. Changing them after reset has no effect on the decode.
- R10: acc_op encodes 00 read, 01 write, 10 erase, 11 fetch. A write or erase that hits region 4 returns out_perm=1 only when upd_en=1. Reads and fetches of any mapped region, and writes or erases of regions 1 to 3, return out_perm=1.
- R11: An unmapped address returns out_err=1, out_region=0 and out_perm=0. The error lasts for that one request's cycle only, and out_err is never 1 together with a nonzero region.
- R12: out_valid is acc_valid delayed by one clock. When out_valid is 0, out_err, out_perm and out_region are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is sampled while low |
| cfg_boot_sel | input | 2 | Boot source field from the first configuration word |
| cfg_data_off | input | 1 | 1 = data area disabled, 0 = enabled |
| cfg_data_base | input | 32 | Data-area base address (page aligned on capture) |
| remap_req | input | 1 | Runtime request to retarget the vector window |
| remap_to_ldr | input | 1 | Window target for remap_req: 1 loader, 0 application |
| acc_valid | input | 1 | Request present this cycle |
| acc_addr | input | 32 | Request byte address |
| acc_op | input | 2 | Request kind: read, write, erase, fetch |
| upd_en | input | 1 | Update enable for configuration-word changes |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_region | output | 3 | Decoded region code |
| out_offset | output | 32 | Offset inside the decoded region |
| out_err | output | 1 | Unmapped address |
| out_perm | output | 1 | Request permitted |

## Verification
Some rules are checked by assertions on every cycle:
- the one-cycle relation between request and result;
- the quiet outputs when idle;
- the exclusion between error and a valid region;
- the offset bounds of the loader and configuration regions;
- the refusal of locked configuration writes and erases.

Other behaviour is stateful and only the bench's scenarios can show it: where the boundary between application and data areas lies for a chosen base, and the vector-window target under each boot setting. The same holds for the exact cycle at which a remap takes effect, and for the configuration inputs being ignored once reset has been released.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

    localparam int FM_AW = 32;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_APP  = 3'd1,
        RG_DATA = 3'd2,
        RG_LDR  = 3'd3,
        RG_CFG  = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_FETCH = 2'd3
    } op_e;

    // boot-time settings plus the live vector-window target
    typedef struct packed {
        logic [1:0]       boot;
        logic             data_off;
        logic [FM_AW-1:0] data_base;
        logic             vec_ldr;
    } map_state_t;

    typedef struct packed {
        logic             valid;
        region_e          region;
        logic [FM_AW-1:0] offset;
        logic             err;
        logic             perm;
    } map_resp_t;

endpackage

// File: rtl/flash_boot_state.sv
module flash_boot_state
    import flash_map_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_boot_sel,
    input  logic             cfg_data_off,
    input  logic [FM_AW-1:0] cfg_data_base,
    input  logic             remap_req,
    input  logic             remap_to_ldr,
    output logic             vec_ldr,
    output logic             data_off,
    output logic [FM_AW-1:0] data_base
);
    localparam logic [FM_AW-1:0] PAGE_MASK = (FM_AW'(1) << PAGE_BITS) - FM_AW'(1);

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.boot      = cfg_boot_sel;
            st_d.data_off  = cfg_data_off;
            st_d.data_base = cfg_data_base & ~PAGE_MASK;
            st_d.vec_ldr   = (cfg_boot_sel == 2'b00);
        end else if (remap_req && st_q.boot[1]) begin
            st_d.vec_ldr = remap_to_ldr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign vec_ldr   = st_q.vec_ldr;
    assign data_off  = st_q.data_off;
    assign data_base = st_q.data_base;

endmodule

// File: rtl/flash_region_decode.sv
module flash_region_decode
    import flash_map_pkg::*;
#(
    parameter logic [FM_AW-1:0] APP_SIZE  = 32'h0008_0000,
    parameter logic [FM_AW-1:0] LDR_BASE  = 32'h0010_0000,
    parameter logic [FM_AW-1:0] LDR_SIZE  = 32'h0000_1000,
    parameter logic [FM_AW-1:0] CFG_BASE  = 32'h0030_0000,
    parameter int               CFG_WORDS = 3,
    parameter logic [FM_AW-1:0] VEC_SIZE  = 32'h0000_0200
) (
    input  logic             vec_ldr,
    input  logic             data_off,
    input  logic [FM_AW-1:0] data_base,
    input  logic [FM_AW-1:0] addr,
    input  logic [1:0]       op,
    input  logic             upd_en,
    output region_e          region,
    output logic [FM_AW-1:0] offset,
    output logic             err,
    output logic             perm
);
    localparam logic [FM_AW-1:0] LDR_END = LDR_BASE + LDR_SIZE;
    localparam logic [FM_AW-1:0] CFG_END = CFG_BASE + FM_AW'(CFG_WORDS * 4);

    logic [FM_AW-1:0] data_lo;
    logic             changes;

    always_comb begin
        // data area starts at the page base, or is empty
        if (data_off || (data_base > APP_SIZE)) data_lo = APP_SIZE;
        else                                    data_lo = data_base;

        region = RG_NONE;
        offset = '0;
        if (vec_ldr && (addr < VEC_SIZE)) begin
            region = RG_LDR;
            offset = addr;
        end else if (addr < data_lo) begin
            region = RG_APP;
            offset = addr;
        end else if (addr < APP_SIZE) begin
            region = RG_DATA;
            offset = addr - data_lo;
        end else if ((addr >= LDR_BASE) && (addr < LDR_END)) begin
            region = RG_LDR;
            offset = addr - LDR_BASE;
        end else if ((addr >= CFG_BASE) && (addr < CFG_END)) begin
            region = RG_CFG;
            offset = addr - CFG_BASE;
        end

        changes = (op == OP_WRITE) || (op == OP_ERASE);
        err     = (region == RG_NONE);
        perm    = !err && ((region != RG_CFG) || !changes || upd_en);
    end

endmodule

// File: rtl/flash_region_map.sv
module flash_region_map
    import flash_map_pkg::*;
#(
    parameter logic [31:0] APP_SIZE  = 32'h0008_0000,
    parameter logic [31:0] LDR_BASE  = 32'h0010_0000,
    parameter logic [31:0] LDR_SIZE  = 32'h0000_1000,
    parameter logic [31:0] CFG_BASE  = 32'h0030_0000,
    parameter int          CFG_WORDS = 3,
    parameter logic [31:0] VEC_SIZE  = 32'h0000_0200,
    parameter int          PAGE_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_boot_sel,
    input  logic        cfg_data_off,
    input  logic [31:0] cfg_data_base,
    input  logic        remap_req,
    input  logic        remap_to_ldr,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_op,
    input  logic        upd_en,
    output logic        out_valid,
    output logic [2:0]  out_region,
    output logic [31:0] out_offset,
    output logic        out_err,
    output logic        out_perm
);
    logic             vec_ldr;
    logic             data_off;
    logic [FM_AW-1:0] data_base;
    region_e          dec_region;
    logic [FM_AW-1:0] dec_offset;
    logic             dec_err;
    logic             dec_perm;

    flash_boot_state #(
        .PAGE_BITS (PAGE_BITS)
    ) i_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_boot_sel  (cfg_boot_sel),
        .cfg_data_off  (cfg_data_off),
        .cfg_data_base (cfg_data_base),
        .remap_req     (remap_req),
        .remap_to_ldr  (remap_to_ldr),
        .vec_ldr       (vec_ldr),
        .data_off      (data_off),
        .data_base     (data_base)
    );

    flash_region_decode #(
        .APP_SIZE  (APP_SIZE),
        .LDR_BASE  (LDR_BASE),
        .LDR_SIZE  (LDR_SIZE),
        .CFG_BASE  (CFG_BASE),
        .CFG_WORDS (CFG_WORDS),
        .VEC_SIZE  (VEC_SIZE)
    ) i_decode (
        .vec_ldr   (vec_ldr),
        .data_off  (data_off),
        .data_base (data_base),
        .addr      (acc_addr),
        .op        (acc_op),
        .upd_en    (upd_en),
        .region    (dec_region),
        .offset    (dec_offset),
        .err       (dec_err),
        .perm      (dec_perm)
    );

    map_resp_t resp_d, resp_q;

    always_comb begin
        resp_d = '0;
        if (rst_n && acc_valid) begin
            resp_d.valid  = 1'b1;
            resp_d.region = dec_region;
            resp_d.offset = dec_offset;
            resp_d.err    = dec_err;
            resp_d.perm   = dec_perm;
        end
    end

    always_ff @(posedge clk) begin
        resp_q <= resp_d;
    end

    assign out_valid  = resp_q.valid;
    assign out_region = resp_q.region;
    assign out_offset = resp_q.offset;
    assign out_err    = resp_q.err;
    assign out_perm   = resp_q.perm;

endmodule

// File: rtl/flash_region_map_chk.sv
module flash_region_map_chk #(
    parameter logic [31:0] LDR_SIZE  = 32'h0000_1000,
    parameter logic [31:0] CFG_BASE  = 32'h0030_0000,
    parameter int          CFG_WORDS = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic [1:0]  acc_op,
    input logic        upd_en,
    input logic        out_valid,
    input logic [2:0]  out_region,
    input logic [31:0] out_offset,
    input logic        out_err,
    input logic        out_perm
);
    localparam logic [31:0] CFG_SIZE = 32'(CFG_WORDS * 4);
    localparam logic [31:0] CFG_END  = CFG_BASE + CFG_SIZE;

    AST_ERR_HAS_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_region == 3'd0 && !out_perm)); // R11
    AST_REGION_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region != 3'd0) |-> !out_err); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_err && !out_perm && out_region == 3'd0)); // R12
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_valid); // R12
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !out_valid); // R12
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_op == 2'd1 || acc_op == 2'd2) && !upd_en
         && acc_addr >= CFG_BASE && acc_addr < CFG_END) |=> !out_perm); // R10
    AST_LDR_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_region == 3'd3) |-> (out_offset < LDR_SIZE)); // R2
    AST_CFG_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_region == 3'd4) |-> (out_offset < CFG_SIZE)); // R3

endmodule

bind flash_region_map flash_region_map_chk #(
    .LDR_SIZE  (LDR_SIZE),
    .CFG_BASE  (CFG_BASE),
    .CFG_WORDS (CFG_WORDS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_op     (acc_op),
    .upd_en     (upd_en),
    .out_valid  (out_valid),
    .out_region (out_region),
    .out_offset (out_offset),
    .out_err    (out_err),
    .out_perm   (out_perm)
);

// File: tb/test_flash_region_map.sv
module test_flash_region_map;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_boot_sel = 2'b01;
    logic        cfg_data_off = 1'b1;
    logic [31:0] cfg_data_base = '0;
    logic        remap_req = 1'b0;
    logic        remap_to_ldr = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_op = 2'd0;
    logic        upd_en = 1'b0;
    logic        out_valid;
    logic [2:0]  out_region;
    logic [31:0] out_offset;
    logic        out_err;
    logic        out_perm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_region_map i_flash_region_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_boot_sel  (cfg_boot_sel),
        .cfg_data_off  (cfg_data_off),
        .cfg_data_base (cfg_data_base),
        .remap_req     (remap_req),
        .remap_to_ldr  (remap_to_ldr),
        .acc_valid     (acc_valid),
        .acc_addr      (acc_addr),
        .acc_op        (acc_op),
        .upd_en        (upd_en),
        .out_valid     (out_valid),
        .out_region    (out_region),
        .out_offset    (out_offset),
        .out_err       (out_err),
        .out_perm      (out_perm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // hold reset with the given boot settings; returns at a falling edge
    task automatic do_reset(input logic [1:0] boot, input logic doff, input logic [31:0] base);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_boot_sel = boot;
        cfg_data_off = doff;
        cfg_data_base = base;
        acc_valid = 1'b0;
        remap_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called at a falling edge; drives one request and checks the next-cycle result
    task automatic access(input string req, input logic [31:0] addr, input logic [1:0] op,
                          input logic upd, input logic [2:0] e_reg, input logic [31:0] e_off,
                          input logic e_err, input logic e_perm);
        acc_valid = 1'b1;
        acc_addr = addr;
        acc_op = op;
        upd_en = upd;
        @(posedge clk);
        #1;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " region"}, 32'(out_region), 32'(e_reg));
        chk({req, " offset"}, out_offset, e_off);
        chk({req, " err"}, 32'(out_err), 32'(e_err));
        chk({req, " perm"}, 32'(out_perm), 32'(e_perm));
        @(negedge clk);
        acc_valid = 1'b0;
        remap_req = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b1;
        acc_addr = 32'h0;
        repeat (2) @(negedge clk);
        chk("R1 in reset valid", 32'(out_valid), 32'd0);
        chk("R1 in reset region", 32'(out_region), 32'd0);
        acc_valid = 1'b0;
        do_reset(2'b01, 1'b1, 32'h0);
        @(posedge clk);
        #1;
        chk("R1 after reset valid", 32'(out_valid), 32'd0);
        chk("R1 after reset err", 32'(out_err), 32'd0);
        chk("R1 after reset perm", 32'(out_perm), 32'd0);
        chk("R12 idle region", 32'(out_region), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_data_off();
        access("R4 low", 32'h0000_0000, 2'd0, 1'b0, 3'd1, 32'h0, 1'b0, 1'b1);
        access("R4 top", 32'h0007_FFFC, 2'd3, 1'b0, 3'd1, 32'h0007_FFFC, 1'b0, 1'b1);
        access("R4 past end", 32'h0008_0000, 2'd0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
        access("R7 window app", 32'h0000_0100, 2'd0, 1'b0, 3'd1, 32'h100, 1'b0, 1'b1);
        access("R10 app write", 32'h0000_1000, 2'd1, 1'b0, 3'd1, 32'h1000, 1'b0, 1'b1);
    endtask

    task automatic t_loader_cfg();
        access("R2 base", 32'h0010_0000, 2'd0, 1'b0, 3'd3, 32'h0, 1'b0, 1'b1);
        access("R2 last", 32'h0010_0FFF, 2'd0, 1'b0, 3'd3, 32'hFFF, 1'b0, 1'b1);
        access("R2 past", 32'h0010_1000, 2'd0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
        access("R3 last word", 32'h0030_0008, 2'd0, 1'b0, 3'd4, 32'h8, 1'b0, 1'b1);
        access("R3 past", 32'h0030_000C, 2'd0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
        access("R10 cfg write locked", 32'h0030_0000, 2'd1, 1'b0, 3'd4, 32'h0, 1'b0, 1'b0);
        access("R10 cfg erase locked", 32'h0030_0004, 2'd2, 1'b0, 3'd4, 32'h4, 1'b0, 1'b0);
        access("R10 cfg erase open", 32'h0030_0004, 2'd2, 1'b1, 3'd4, 32'h4, 1'b0, 1'b1);
        access("R10 cfg write open", 32'h0030_0000, 2'd1, 1'b1, 3'd4, 32'h0, 1'b0, 1'b1);
        access("R11 far", 32'hFFFF_FFF0, 2'd0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
        @(posedge clk);
        #1;
        chk("R11 err one cycle", 32'(out_err), 32'd0);
        chk("R12 idle valid", 32'(out_valid), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_remap_ignored();
        remap_req = 1'b1;
        remap_to_ldr = 1'b1;
        @(negedge clk);
        remap_req = 1'b0;
        access("R7 remap ignored", 32'h0000_0004, 2'd3, 1'b0, 3'd1, 32'h4, 1'b0, 1'b1);
    endtask

    task automatic t_loader_boot_data();
        do_reset(2'b00, 1'b0, 32'h0007_A123);
        access("R6 vector ldr", 32'h0000_0004, 2'd3, 1'b0, 3'd3, 32'h4, 1'b0, 1'b1);
        access("R6 window edge", 32'h0000_01FC, 2'd3, 1'b0, 3'd3, 32'h1FC, 1'b0, 1'b1);
        access("R6 after window", 32'h0000_0200, 2'd0, 1'b0, 3'd1, 32'h200, 1'b0, 1'b1);
        access("R5 app below base", 32'h0007_9FFF, 2'd0, 1'b0, 3'd1, 32'h0007_9FFF, 1'b0, 1'b1);
        access("R5 data base", 32'h0007_A000, 2'd0, 1'b0, 3'd2, 32'h0, 1'b0, 1'b1);
        access("R5 data top", 32'h0007_FFFF, 2'd0, 1'b0, 3'd2, 32'h5FFF, 1'b0, 1'b1);
        // configuration inputs change after reset: decode must not move
        cfg_boot_sel = 2'b01;
        cfg_data_off = 1'b1;
        cfg_data_base = 32'h0001_0000;
        repeat (2) @(negedge clk);
        access("R9 window kept", 32'h0000_0008, 2'd0, 1'b0, 3'd3, 32'h8, 1'b0, 1'b1);
        access("R9 data kept", 32'h0007_A010, 2'd0, 1'b0, 3'd2, 32'h10, 1'b0, 1'b1);
    endtask

    task automatic t_runtime_remap();
        do_reset(2'b10, 1'b1, 32'h0);
        access("R8 start app", 32'h0000_0004, 2'd3, 1'b0, 3'd1, 32'h4, 1'b0, 1'b1);
        remap_req = 1'b1;
        remap_to_ldr = 1'b1;
        access("R8 same cycle old", 32'h0000_0008, 2'd3, 1'b0, 3'd1, 32'h8, 1'b0, 1'b1);
        access("R8 next cycle ldr", 32'h0000_0008, 2'd3, 1'b0, 3'd3, 32'h8, 1'b0, 1'b1);
        access("R8 ldr unchanged", 32'h0010_0004, 2'd0, 1'b0, 3'd3, 32'h4, 1'b0, 1'b1);
        access("R8 app unchanged", 32'h0007_FFFC, 2'd0, 1'b0, 3'd1, 32'h0007_FFFC, 1'b0, 1'b1);
        remap_req = 1'b1;
        remap_to_ldr = 1'b0;
        @(negedge clk);
        remap_req = 1'b0;
        access("R8 back to app", 32'h0000_0008, 2'd3, 1'b0, 3'd1, 32'h8, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_data_off();
        t_loader_cfg();
        t_remap_ignored();
        t_loader_boot_data();
        t_runtime_remap();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule